// File: doc/BRIEF.md
# Quadratic Delay and Phase Model Evaluator

This block turns two sets of quadratic coefficients into a running delay model and a running phase model. Control logic writes a delay triple and a phase triple into a holding bank at any time. An integration-start strobe copies the held triple into the working registers, and both polynomials restart from their constant term. Neither polynomial uses a multiplier. Each one is stepped by forward differencing: one accumulator, one first-difference register and two additions per step.

The two models advance at different rates. The phase model advances on every sample strobe. Its upper bits form a phase word that wraps modulo one turn and feeds a quadrature mixer downstream. The delay model advances once per transform frame, which is a parameterised count of sample strobes. The delay value carries eight fractional bits in 1/256-sample units. It is split into an integer part, which selects the first sample to read at integration start, and a fractional part, which a later stage converts to a band-centre phase. A one-cycle update flag marks every cycle in which a new delay value has just appeared.

Top module: `quad_model_eval`

## Requirements
- R1: After reset, `dly_int`, `dly_frac`, `ph_word` and `dly_upd` are all zero.
- R2: A high `coef_load` stores all six coefficient inputs in a holding bank and has no effect on the outputs by itself. When `coef_load` and `int_start` are high in the same cycle, the integration starts with the previously held coefficients.
- R3: In the cycle after `int_start`, the outputs show the held constant terms. The delay value is the delay c0, and `ph_word` is phase c0 bits [63:48]. `int_start` may arrive at any time, restarts both models, and takes priority over `samp_en`.
- R4: After n accepted sample strobes since the last start, the phase accumulator equals (c0 + c1·n + c2·n²) mod 2^64, and `ph_word` is its bits [63:48].
- R5: The delay value changes only on the accepted sample strobe that completes a frame of SAMP_PER_FFT samples. After k completed frames it equals (c0 + c1·k + c2·k²) mod 2^48.
- R6: The 48-bit delay value is output as `dly_int` = bits [47:8] (whole samples) and `dly_frac` = bits [7:0] (1/256 sample).
- R7: `dly_upd` is high for exactly the one cycle after an integration start and the one cycle after each frame-completing sample strobe. It is low in every other cycle.
- R8: In a cycle with neither `samp_en` nor `int_start`, all model outputs hold their values.
- R9: Before the first `int_start` after reset, `samp_en` is ignored and the outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_load | input | 1 | Store the six coefficient inputs in the holding bank |
| dly_c0 | input | 48 | Delay constant term (1/256 sample units) |
| dly_c1 | input | 48 | Delay linear term per frame |
| dly_c2 | input | 48 | Delay quadratic term per frame squared |
| ph_c0 | input | 64 | Phase constant term (full scale = one turn) |
| ph_c1 | input | 64 | Phase linear term per sample |
| ph_c2 | input | 64 | Phase quadratic term per sample squared |
| int_start | input | 1 | Integration start: activate held coefficients and restart |
| samp_en | input | 1 | One sample has elapsed |
| dly_int | output | 40 | Integer sample delay |
| dly_frac | output | 8 | Fractional delay, 1/256 sample |
| dly_upd | output | 1 | A new delay value was produced in the previous cycle |
| ph_word | output | 16 | Phase word for the mixer |

## Verification
The hardest case to reach from the ports is a coefficient load that lands in the same cycle as an integration start. It is only visible because the held bank already contains a different set, so the bench loads one set and starts with it, then drives a second set with both strobes together and expects the restart to use the first set. Frame boundaries are reached with a short frame length of four samples. An irregular sample-strobe pattern makes boundaries fall both right after gaps and in runs of back-to-back samples. Coefficient sets with negative terms and near-full-scale constants drive the 48-bit and 64-bit wrap.

// File: rtl/qme_pkg.sv
package qme_pkg;
   localparam int unsigned DEF_DLY_W   = 48;
   localparam int unsigned DEF_PH_W    = 64;
   localparam int unsigned DEF_FRAC_W  = 8;
   localparam int unsigned DEF_PHO_W   = 16;
   localparam int unsigned DEF_SPF     = 2048;
   localparam int unsigned NUM_COEF    = 3;

   typedef enum logic [1:0] {
      CF_CONST = 2'd0,
      CF_LIN   = 2'd1,
      CF_QUAD  = 2'd2
   } coef_idx_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/qme_coef_bank.sv
module qme_coef_bank #(
   parameter int unsigned W     = 48,
   parameter int unsigned NCOEF = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [NCOEF-1:0][W-1:0]     din,
   input  logic                        activate,
   output logic [NCOEF-1:0][W-1:0]     held,
   output logic [NCOEF-1:0][W-1:0]     active
);
   genvar gi;
   generate
      for (gi = 0; gi < NCOEF; gi++) begin : g_coef
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held[gi]   <= '0;
               active[gi] <= '0;
            end else begin
               if (activate) active[gi] <= held[gi];
               if (load)     held[gi]   <= din[gi];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qme_fwd_diff.sv
module qme_fwd_diff #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         step,
   input  logic [W-1:0] c0,
   input  logic [W-1:0] c1,
   input  logic [W-1:0] c2,
   output logic [W-1:0] value
);
   logic [W-1:0] diff1;
   logic [W-1:0] diff2;

   assign diff2 = {c2[W-2:0], 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
         diff1 <= '0;
      end else if (init) begin
         value <= c0;
         diff1 <= c1 + c2;
      end else if (step) begin
         value <= value + diff1;
         diff1 <= diff1 + diff2;
      end
   end
endmodule

// File: rtl/qme_frame_timer.sv
module qme_frame_timer #(
   parameter int unsigned SPF   = 2048,
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   output logic             frame_done,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SPF - 1);

   assign frame_done = step && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (init)       cnt <= '0;
      else if (frame_done) cnt <= '0;
      else if (step)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/quad_model_eval.sv
module quad_model_eval #(
   parameter int unsigned DLY_W         = qme_pkg::DEF_DLY_W,
   parameter int unsigned PH_W          = qme_pkg::DEF_PH_W,
   parameter int unsigned FRAC_W        = qme_pkg::DEF_FRAC_W,
   parameter int unsigned PH_OUT_W      = qme_pkg::DEF_PHO_W,
   parameter int unsigned SAMP_PER_FFT  = qme_pkg::DEF_SPF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      coef_load,
   input  logic [DLY_W-1:0]          dly_c0,
   input  logic [DLY_W-1:0]          dly_c1,
   input  logic [DLY_W-1:0]          dly_c2,
   input  logic [PH_W-1:0]           ph_c0,
   input  logic [PH_W-1:0]           ph_c1,
   input  logic [PH_W-1:0]           ph_c2,
   input  logic                      int_start,
   input  logic                      samp_en,
   output logic [DLY_W-FRAC_W-1:0]   dly_int,
   output logic [FRAC_W-1:0]         dly_frac,
   output logic                      dly_upd,
   output logic [PH_OUT_W-1:0]       ph_word
);
   import qme_pkg::*;

   localparam int unsigned NC    = NUM_COEF;
   localparam int unsigned CNT_W = cnt_width(SAMP_PER_FFT);
   localparam int unsigned INT_W = DLY_W - FRAC_W;

   generate
      if (FRAC_W == 0 || FRAC_W >= DLY_W) begin : g_bad_frac
         $error("FRAC_W must lie strictly between 0 and DLY_W");
      end
      if (PH_OUT_W == 0 || PH_OUT_W > PH_W) begin : g_bad_pho
         $error("PH_OUT_W must lie in 1..PH_W");
      end
      if (SAMP_PER_FFT < 2) begin : g_bad_spf
         $error("SAMP_PER_FFT must be at least 2");
      end
      if (DLY_W < 2 || PH_W < 2) begin : g_bad_w
         $error("accumulator widths must be at least 2");
      end
   endgenerate

   logic                       running;
   logic                       samp_ok;
   logic                       frame_done;
   logic [CNT_W-1:0]           fft_cnt;
   logic [NC-1:0][DLY_W-1:0]   dly_din, dly_held, dly_act;
   logic [NC-1:0][PH_W-1:0]    ph_din,  ph_held,  ph_act;
   logic [DLY_W-1:0]           dly_val;
   logic [PH_W-1:0]            ph_val;

   assign dly_din[CF_CONST] = dly_c0;
   assign dly_din[CF_LIN]   = dly_c1;
   assign dly_din[CF_QUAD]  = dly_c2;
   assign ph_din[CF_CONST]  = ph_c0;
   assign ph_din[CF_LIN]    = ph_c1;
   assign ph_din[CF_QUAD]   = ph_c2;

   // A start wins over a sample arriving in the same cycle.
   assign samp_ok = samp_en && running && !int_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         dly_upd <= 1'b0;
      end else begin
         if (int_start) running <= 1'b1;
         dly_upd <= int_start || frame_done;
      end
   end

   qme_coef_bank #(.W(DLY_W), .NCOEF(NC)) u_dly_bank (
      .clk(clk), .rst_n(rst_n), .load(coef_load), .din(dly_din),
      .activate(int_start), .held(dly_held), .active(dly_act)
   );

   qme_coef_bank #(.W(PH_W), .NCOEF(NC)) u_ph_bank (
      .clk(clk), .rst_n(rst_n), .load(coef_load), .din(ph_din),
      .activate(int_start), .held(ph_held), .active(ph_act)
   );

   // Initial values come from the held bank, which the active bank copies on the same edge.
   qme_fwd_diff #(.W(DLY_W)) u_dly_fd (
      .clk(clk), .rst_n(rst_n), .init(int_start), .step(frame_done),
      .c0(int_start ? dly_held[CF_CONST] : dly_act[CF_CONST]),
      .c1(int_start ? dly_held[CF_LIN]   : dly_act[CF_LIN]),
      .c2(int_start ? dly_held[CF_QUAD]  : dly_act[CF_QUAD]),
      .value(dly_val)
   );

   qme_fwd_diff #(.W(PH_W)) u_ph_fd (
      .clk(clk), .rst_n(rst_n), .init(int_start), .step(samp_ok),
      .c0(int_start ? ph_held[CF_CONST] : ph_act[CF_CONST]),
      .c1(int_start ? ph_held[CF_LIN]   : ph_act[CF_LIN]),
      .c2(int_start ? ph_held[CF_QUAD]  : ph_act[CF_QUAD]),
      .value(ph_val)
   );

   qme_frame_timer #(.SPF(SAMP_PER_FFT), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .init(int_start), .step(samp_ok),
      .frame_done(frame_done), .cnt(fft_cnt)
   );

   assign dly_int  = dly_val[DLY_W-1 -: INT_W];
   assign dly_frac = dly_val[FRAC_W-1:0];

   generate
      if (PH_OUT_W == PH_W) begin : g_ph_full
         assign ph_word = ph_val;
      end else begin : g_ph_top
         assign ph_word = ph_val[PH_W-1 -: PH_OUT_W];
      end
   endgenerate
endmodule

// File: rtl/qme_checker.sv
module qme_checker #(
   parameter int unsigned DLY_W        = 48,
   parameter int unsigned PH_W         = 64,
   parameter int unsigned FRAC_W       = 8,
   parameter int unsigned PH_OUT_W     = 16,
   parameter int unsigned SAMP_PER_FFT = 2048,
   parameter int unsigned CNT_W        = 11
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    int_start,
   input logic                    samp_en,
   input logic                    running,
   input logic [CNT_W-1:0]        fft_cnt,
   input logic [PH_W-1:0]         ph_held_c0,
   input logic [DLY_W-FRAC_W-1:0] dly_int,
   input logic [FRAC_W-1:0]       dly_frac,
   input logic                    dly_upd,
   input logic [PH_OUT_W-1:0]     ph_word
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMP_PER_FFT - 1);

   p_start_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |=> ph_word == $past(ph_held_c0[PH_W-1 -: PH_OUT_W]));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_start && !samp_en) |=> ($stable(ph_word) && $stable(dly_int) && $stable(dly_frac)));

   p_upd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int_start |=> dly_upd);

   p_upd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dly_upd |-> ($past(int_start) || ($past(samp_en) && $past(fft_cnt) == LAST)));

   p_dly_mid_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_start && fft_cnt != LAST) |=> ($stable(dly_int) && $stable(dly_frac)));

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (ph_word == '0 && dly_int == '0 && dly_frac == '0));
endmodule

bind quad_model_eval qme_checker #(
   .DLY_W(DLY_W), .PH_W(PH_W), .FRAC_W(FRAC_W), .PH_OUT_W(PH_OUT_W),
   .SAMP_PER_FFT(SAMP_PER_FFT), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .int_start(int_start), .samp_en(samp_en),
   .running(running), .fft_cnt(fft_cnt), .ph_held_c0(ph_held[0]),
   .dly_int(dly_int), .dly_frac(dly_frac), .dly_upd(dly_upd), .ph_word(ph_word)
);

// File: tb/quad_model_eval_test.sv
`timescale 1ns/1ps
module quad_model_eval_test;
   localparam int unsigned SPF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic coef_load = 1'b0, int_start = 1'b0, samp_en = 1'b0;
   logic [47:0] dly_c0 = '0, dly_c1 = '0, dly_c2 = '0;
   logic [63:0] ph_c0 = '0, ph_c1 = '0, ph_c2 = '0;
   logic [39:0] dly_int;
   logic [7:0]  dly_frac;
   logic        dly_upd;
   logic [15:0] ph_word;

   int vectors = 0;
   int errors  = 0;
   bit done = 1'b0;

   // bench model state
   logic [63:0] m_held [6];
   logic [63:0] m_act  [6];
   int          m_n = 0;
   bit          m_run = 1'b0;
   bit          m_upd = 1'b0;

   always #4 clk = ~clk;

   quad_model_eval #(.SAMP_PER_FFT(SPF)) uut (
      .clk(clk), .rst_n(rst_n), .coef_load(coef_load),
      .dly_c0(dly_c0), .dly_c1(dly_c1), .dly_c2(dly_c2),
      .ph_c0(ph_c0), .ph_c1(ph_c1), .ph_c2(ph_c2),
      .int_start(int_start), .samp_en(samp_en),
      .dly_int(dly_int), .dly_frac(dly_frac), .dly_upd(dly_upd), .ph_word(ph_word)
   );

   function automatic logic [63:0] coef(input int set, input int idx);
      logic [63:0] v;
      case (set * 6 + idx)
         0:  v = 64'h0000_1234_56AB;
         1:  v = 64'h0000_0000_0123;
         2:  v = 64'h0000_0000_0003;
         3:  v = 64'h0000_0000_0000_0000;
         4:  v = 64'h0123_4567_89AB_CDEF;
         5:  v = 64'h0000_0000_0001_0010;
         6:  v = 64'h0000_0100_0080;
         7:  v = 64'hFFFF_FFFF_FE80;
         8:  v = 64'hFFFF_FFFF_FFFF;
         9:  v = 64'hFFF0_0000_0000_0000;
         10: v = 64'hF000_0000_0000_0001;
         11: v = 64'h0800_0000_0000_0003;
         12: v = 64'hFFFF_FFFF_FFFB;
         13: v = 64'h0000_0000_0207;
         14: v = 64'h0000_0040_0000;
         15: v = 64'h7FFF_FFFF_FFFF_FFF0;
         16: v = 64'h8000_0000_0000_0000;
         17: v = 64'hFFFF_FFFF_FFFF_FFFF;
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic present(input int set);
      dly_c0 = coef(set, 0)[47:0];
      dly_c1 = coef(set, 1)[47:0];
      dly_c2 = coef(set, 2)[47:0];
      ph_c0  = coef(set, 3);
      ph_c1  = coef(set, 4);
      ph_c2  = coef(set, 5);
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      logic [63:0] n, k, ph, dl;
      if (!m_run) begin
         ph = '0; dl = '0;
      end else begin
         n  = 64'(m_n);
         k  = 64'(m_n / SPF);
         ph = m_act[3] + m_act[4] * n + m_act[5] * n * n;
         dl = (m_act[0] + m_act[1] * k + m_act[2] * k * k) & 64'h0000_FFFF_FFFF_FFFF;
      end
      check({req, "/R4 phase"}, 64'(ph_word), 64'(ph[63:48]));
      check({req, "/R6 int"},   64'(dly_int), 64'(dl[47:8]));
      check({req, "/R6 frac"},  64'(dly_frac), 64'(dl[7:0]));
      check({req, "/R7 upd"},   64'(dly_upd), 64'(m_upd));
   endtask

   // One clock: inputs are set now (after a falling edge), results checked at the next falling edge.
   task automatic cyc(input bit load, input bit start, input bit samp, input string req);
      coef_load = load; int_start = start; samp_en = samp;
      @(posedge clk);
      m_upd = 1'b0;
      if (start) begin
         for (int i = 0; i < 6; i++) m_act[i] = m_held[i];
         m_n = 0; m_run = 1'b1; m_upd = 1'b1;
      end else if (samp && m_run) begin
         m_n++;
         m_upd = (m_n % SPF) == 0;
      end
      if (load) begin
         m_held[0] = 64'(dly_c0); m_held[1] = 64'(dly_c1); m_held[2] = 64'(dly_c2);
         m_held[3] = ph_c0;       m_held[4] = ph_c1;       m_held[5] = ph_c2;
      end
      @(negedge clk);
      coef_load = 1'b0; int_start = 1'b0; samp_en = 1'b0;
      check_outputs(req);
   endtask

   task automatic run(input int cycles, input int pat, input string req);
      for (int i = 0; i < cycles; i++) begin
         bit s;
         s = ((i + pat) % 5) != 2;
         cyc(1'b0, 1'b0, s, req);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 6; i++) begin m_held[i] = '0; m_act[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_outputs("R1 reset");

      // R9: sample strobes before any start do nothing
      run(7, 0, "R9 idle");

      // R2: loading alone leaves outputs untouched
      present(0);
      cyc(1'b1, 1'b0, 1'b0, "R2 load only");
      run(3, 1, "R2 after load");

      // R3: start, then R4/R5 stepping with gaps (R8)
      cyc(1'b0, 1'b1, 1'b1, "R3 start beats samp");
      run(40, 0, "R5 set0");
      cyc(1'b0, 1'b0, 1'b0, "R8 hold");
      cyc(1'b0, 1'b0, 1'b0, "R8 hold");

      // R2: load of set1 together with start restarts using set0
      present(1);
      cyc(1'b1, 1'b1, 1'b0, "R2 load+start old set");
      run(13, 3, "R2 old set running");
      cyc(1'b0, 1'b1, 1'b0, "R3 restart new set");
      run(45, 2, "R4 set1 wrap");

      // load set2 mid-integration: no effect until start
      present(2);
      cyc(1'b1, 1'b0, 1'b1, "R2 load mid run");
      run(6, 4, "R2 still set1");
      cyc(1'b0, 1'b1, 1'b0, "R3 start set2");
      for (int i = 0; i < 3 * SPF + 1; i++) cyc(1'b0, 1'b0, 1'b1, "R5 back-to-back");
      run(30, 1, "R6 set2 wrap");

      // reset mid run returns everything to zero and idle
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_run = 1'b0; m_upd = 1'b0; m_n = 0;
      for (int i = 0; i < 6; i++) begin m_held[i] = '0; m_act[i] = '0; end
      check_outputs("R1 re-reset");
      run(5, 0, "R9 idle after reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule